// File: doc/BRIEF.md
# Transmit Preamble Length Timer

This block measures out the preamble of an outgoing burst in symbol periods. Software sets an 8-bit length value while the transmitter is idle. When transmit enable goes high, the block counts a fixed amplifier ramp interval and then the programmed number of symbols. It then issues a one-cycle completion pulse, so that header generation can start on the next symbol. It only counts: it does not produce preamble bits or header bits.

Only symbol strobes advance the count. The burst therefore always lasts the programmed value plus the two ramp symbols. A value of 128 gives 130 strobes, and a value of 0 gives only the two ramp strobes. The usual wireless LAN setting is 0x80. Receivers that use one antenna can run with settings down to about 0x50. Receivers that switch between two antennas need at least 0x80.

The length register may only be changed while transmit enable is low. A write made while it is high has no effect and sets a sticky flag that only reset clears. If transmit enable falls before the count finishes, the burst is abandoned silently.

Top module: `tx_preamble_timer`

## Requirements
- R1: After a synchronous reset, `cfg_len` reads 0x80 and `pa_ramp`, `pre_done` and `wr_rejected` are all low.
- R2: A write (`cfg_we`=1) sampled while `tx_en` is low loads `cfg_wdata` into the length register. `cfg_len` shows the new value one cycle later.
- R3: A write sampled while `tx_en` is high is ignored, and `cfg_len` keeps its previous value.
- R4: A write sampled while `tx_en` is high sets `wr_rejected` one cycle later. The flag then stays high until reset.
- R5: From idle, a clock edge that samples `tx_en` high starts a burst. `pa_ramp` goes high in the next cycle and falls in the cycle after the edge that takes the second counted symbol strobe.
- R6: `pre_done` is high for exactly one cycle. That cycle follows the edge that takes counted strobe number L+2, where L is the programmed length.
- R7: With L = 0, `pre_done` rises in the same cycle that `pa_ramp` falls. `pa_ramp` and `pre_done` are never high together.
- R8: If `tx_en` is sampled low before the count completes, the burst is abandoned. Both outputs are low in the next cycle, and no `pre_done` follows for that burst.
- R9: Once `pre_done` has fired, no further pulse occurs until `tx_en` has been sampled low and then high again.
- R10: A `sym_stb` in the same cycle that starts the burst is not counted.
- R11: A cycle with `tx_en` low and `sym_stb` high counts as an abort, never as the final strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Length register write strobe |
| cfg_wdata | input | 8 | Length value to write |
| cfg_len | output | 8 | Current length register value |
| tx_en | input | 1 | Transmit enable; a rise starts a burst |
| sym_stb | input | 1 | One-cycle symbol period strobe |
| pa_ramp | output | 1 | High during the amplifier ramp symbols |
| pre_done | output | 1 | One-cycle pulse at the end of the preamble |
| wr_rejected | output | 1 | Sticky flag for a write refused while transmitting |

## Verification
The bench aims at the off-by-one traps in the count. If the strobe in the start cycle were counted, every burst would end one symbol early. If the ramp were skipped, or the length latched wrongly, the burst length would differ from L+2. The bench also covers L = 0 and L = 255: a decrement that underflows at zero would run for about 256 extra symbols, and a length truncated to the wrong width would miss 257. It drives writes during a burst to catch a register that accepts them or a flag that fails to stick. It drops transmit enable together with the final strobe and holds it high after completion. These cases expose a design that finishes on an abort or fires a second pulse.

// File: rtl/pream_pkg.sv
package pream_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RAMP = 2'd1,
    PH_BODY = 2'd2,
    PH_HOLD = 2'd3
  } pream_phase_e;
endpackage

// File: rtl/pream_len_reg.sv
module pream_len_reg #(
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned LEN_RST = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LEN_W-1:0] wdata,
  input  logic             tx_en,
  output logic [LEN_W-1:0] len_q,
  output logic             rej_q
);
  logic accept;
  logic refuse;

  assign accept = we & ~tx_en;
  assign refuse = we & tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_W'(LEN_RST);
      rej_q <= 1'b0;
    end else begin
      if (accept) len_q <= wdata;
      if (refuse) rej_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pream_down_cnt.sv
module pream_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - W'(1);
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/pream_seq.sv
module pream_seq
  import pream_pkg::*;
#(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned RAMP_SYMS = 2   // must be at least 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             sym_stb,
  input  logic [LEN_W-1:0] len,
  output logic             pa_ramp,
  output logic             pre_done
);
  localparam int unsigned RAMP_W = $clog2(RAMP_SYMS + 1);

  pream_phase_e ph_q, ph_nxt;
  logic ramp_load, ramp_dec, ramp_last;
  logic body_load, body_dec, body_last;
  logic done_nxt;

  pream_down_cnt #(.W(RAMP_W)) i_ramp_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ramp_load),
    .load_val (RAMP_W'(RAMP_SYMS)),
    .dec      (ramp_dec),
    .last     (ramp_last)
  );

  pream_down_cnt #(.W(LEN_W)) i_body_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (body_load),
    .load_val (len),
    .dec      (body_dec),
    .last     (body_last)
  );

  always_comb begin
    ph_nxt    = ph_q;
    ramp_load = 1'b0;
    ramp_dec  = 1'b0;
    body_load = 1'b0;
    body_dec  = 1'b0;
    done_nxt  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (tx_en) begin
          ph_nxt    = PH_RAMP;
          ramp_load = 1'b1;
        end
      end
      PH_RAMP: begin
        if (!tx_en) begin
          ph_nxt = PH_IDLE;
        end else if (sym_stb) begin
          if (ramp_last) begin
            if (len == '0) begin
              ph_nxt   = PH_HOLD;
              done_nxt = 1'b1;
            end else begin
              ph_nxt    = PH_BODY;
              body_load = 1'b1;
            end
          end else begin
            ramp_dec = 1'b1;
          end
        end
      end
      PH_BODY: begin
        if (!tx_en) begin
          ph_nxt = PH_IDLE;
        end else if (sym_stb) begin
          if (body_last) begin
            ph_nxt   = PH_HOLD;
            done_nxt = 1'b1;
          end else begin
            body_dec = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (!tx_en) ph_nxt = PH_IDLE;
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      pa_ramp  <= 1'b0;
      pre_done <= 1'b0;
    end else begin
      ph_q     <= ph_nxt;
      pa_ramp  <= (ph_nxt == PH_RAMP);
      pre_done <= done_nxt;
    end
  end
endmodule

// File: rtl/tx_preamble_timer.sv
module tx_preamble_timer #(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned LEN_RST   = 128,
  parameter int unsigned RAMP_SYMS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_wdata,
  output logic [LEN_W-1:0] cfg_len,
  input  logic             tx_en,
  input  logic             sym_stb,
  output logic             pa_ramp,
  output logic             pre_done,
  output logic             wr_rejected
);
  pream_len_reg #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) i_len_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .tx_en (tx_en),
    .len_q (cfg_len),
    .rej_q (wr_rejected)
  );

  pream_seq #(.LEN_W(LEN_W), .RAMP_SYMS(RAMP_SYMS)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .sym_stb  (sym_stb),
    .len      (cfg_len),
    .pa_ramp  (pa_ramp),
    .pre_done (pre_done)
  );
endmodule

// File: rtl/tx_preamble_timer_chk.sv
module tx_preamble_timer_chk #(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [LEN_W-1:0] cfg_wdata,
  input logic [LEN_W-1:0] cfg_len,
  input logic             tx_en,
  input logic             sym_stb,
  input logic             pa_ramp,
  input logic             pre_done,
  input logic             wr_rejected
);
  assert_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !tx_en) |=> (cfg_len == $past(cfg_wdata)));

  assert_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && tx_en) |=> $stable(cfg_len));

  assert_reject_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    wr_rejected |=> wr_rejected);

  assert_reject_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_rejected) |-> $past(cfg_we && tx_en));

  assert_ramp_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pa_ramp) |-> $past(tx_en));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    pre_done |=> !pre_done);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(pa_ramp && pre_done));

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!tx_en) |=> (!pa_ramp && !pre_done));

  assert_done_needs_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(pre_done) |-> $past(sym_stb && tx_en));
endmodule

bind tx_preamble_timer tx_preamble_timer_chk #(.LEN_W(LEN_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .cfg_len     (cfg_len),
  .tx_en       (tx_en),
  .sym_stb     (sym_stb),
  .pa_ramp     (pa_ramp),
  .pre_done    (pre_done),
  .wr_rejected (wr_rejected)
);

// File: tb/test_tx_preamble_timer.sv
`timescale 1ns/1ps
module test_tx_preamble_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_len;
  logic       tx_en = 1'b0;
  logic       sym_stb = 1'b0;
  logic       pa_ramp, pre_done, wr_rejected;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tx_preamble_timer i_tx_preamble_timer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_len(cfg_len), .tx_en(tx_en), .sym_stb(sym_stb),
    .pa_ramp(pa_ramp), .pre_done(pre_done), .wr_rejected(wr_rejected)
  );

  // behavioural reference: strobes seen since start versus target len+2
  bit m_valid = 0, m_busy = 0, m_hold = 0, m_rej = 0, m_done = 0, m_ramp = 0;
  int m_seen = 0, m_len = 128;

  always @(posedge clk) begin
    m_valid = 1;
    if (rst) begin
      m_busy = 0; m_hold = 0; m_seen = 0; m_len = 128;
      m_rej = 0; m_done = 0; m_ramp = 0;
    end else begin
      m_done = 0;
      if (cfg_we) begin
        if (tx_en) m_rej = 1;
        else       m_len = int'(cfg_wdata);
      end
      if (m_busy) begin
        if (!tx_en) m_busy = 0;
        else if (sym_stb) begin
          m_seen++;
          if (m_seen == m_len + 2) begin
            m_done = 1; m_busy = 0; m_hold = 1;
          end
        end
      end else if (m_hold) begin
        if (!tx_en) m_hold = 0;
      end else if (tx_en) begin
        m_busy = 1; m_seen = 0;
      end
      m_ramp = m_busy && (m_seen < 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (m_valid) begin
      chk(cfg_len == m_len[7:0], "R2 model cfg_len", int'(cfg_len), m_len);
      chk(pa_ramp == m_ramp, "R5 model pa_ramp", int'(pa_ramp), int'(m_ramp));
      chk(pre_done == m_done, "R6 model pre_done", int'(pre_done), int'(m_done));
      chk(wr_rejected == m_rej, "R4 model wr_rejected", int'(wr_rejected), int'(m_rej));
    end
    if (cycles > 60000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic bit pat(input int mode, input int i);
    case (mode)
      0:       return 1'b1;
      1:       return (i % 3) == 2;
      default: return ((i * 7) % 5) < 2;
    endcase
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // run one burst; returns counted strobes up to and including the done edge
  task automatic burst(input int mode, input bit bad_wr, output int nstb);
    nstb = 0;
    @(negedge clk); tx_en = 1'b1; sym_stb = 1'b1;  // R10: start-cycle strobe
    @(negedge clk);
    chk(pa_ramp == 1'b1, "R5 ramp high after start", int'(pa_ramp), 1);
    for (int i = 0; i < 2000; i++) begin
      sym_stb   = pat(mode, i);
      cfg_we    = bad_wr && (i == 3);
      cfg_wdata = 8'h11;
      @(negedge clk);
      if (sym_stb) nstb++;
      if (pre_done) begin
        chk(pa_ramp == 1'b0, "R7 ramp low at done", int'(pa_ramp), 0);
        break;
      end
    end
    cfg_we = 1'b0; sym_stb = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(pre_done == 1'b0, "R9 no second pulse", int'(pre_done), 0);
    end
    sym_stb = 1'b0; tx_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    int seen_done;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_len == 8'h80, "R1 reset len", int'(cfg_len), 128);
    chk(!pa_ramp && !pre_done && !wr_rejected, "R1 reset outputs",
        int'({pa_ramp, pre_done, wr_rejected}), 0);

    wr(8'h50);
    chk(cfg_len == 8'h50, "R2 write while idle", int'(cfg_len), 80);

    burst(0, 1'b0, n);
    chk(n == 82, "R6 R10 length 0x50 dense", n, 82);

    burst(1, 1'b1, n);
    chk(n == 82, "R3 length unchanged by refused write", n, 82);
    chk(cfg_len == 8'h50, "R3 cfg_len after refused write", int'(cfg_len), 80);
    chk(wr_rejected == 1'b1, "R4 flag set", int'(wr_rejected), 1);

    wr(8'h00);
    burst(1, 1'b0, n);
    chk(n == 2, "R7 zero length", n, 2);

    wr(8'h80);
    burst(2, 1'b0, n);
    chk(n == 130, "R6 length 0x80 irregular", n, 130);

    wr(8'hFF);
    burst(0, 1'b0, n);
    chk(n == 257, "R6 length 0xFF", n, 257);

    // R8 and R11: abort on what would be the final strobe
    wr(8'h05);
    seen_done = 0;
    @(negedge clk); tx_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sym_stb = 1'b1;
    end
    @(negedge clk); sym_stb = 1'b1; tx_en = 1'b0;
    @(negedge clk); sym_stb = 1'b0;
    chk(!pa_ramp && !pre_done, "R11 abort wins over final strobe",
        int'({pa_ramp, pre_done}), 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (pre_done) seen_done++;
    end
    chk(seen_done == 0, "R8 no done after abort", seen_done, 0);

    burst(2, 1'b0, n);
    chk(n == 7, "R8 restart after abort", n, 7);
    chk(wr_rejected == 1'b1, "R4 flag still sticky", int'(wr_rejected), 1);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!wr_rejected && cfg_len == 8'h80, "R1 reset clears flag and len",
        int'({wr_rejected, cfg_len}), 128);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule